// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a small synchronous SRAM. Its 32-bit data path is split into four byte lanes. Every rising clock edge captures the address, the three chip selects, the read/write select, the per-lane write strobes and the load/advance control. Read data flows straight out of the array during the cycle that follows the address edge, with no output register. Write data is taken one cycle after its address, together with the strobes captured alongside that address. A read can therefore follow a write, or a write follow a read, on consecutive edges with no idle cycle.

A load cycle opens an access at the external address. Each advance cycle then steps a 2-bit burst counter through a 4-word aligned block and wraps at the block boundary. A stall input freezes every register as if the previous cycle were stretched. A combinational output enable gates only the data drivers. An asynchronous doze input freezes the block and keeps the array contents. The bidirectional pads are modelled as separate `din`, `dout` and `dout_en` ports.

Top module: `fzt_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release with no access loaded, `dout_en` is 0 and `dout` is all zeros.
- R2: On an edge with `ld_adv`=0 and the block selected, the address and the operation are captured (`rd_wr`=1 read, 0 write). For a read, `dout_en`=1 and `dout` shows the word at that address during the following cycle. For a write, `din` is stored at the following edge.
- R3: `byte_wr_n[i]` (active low) controls bits `8*i+7:8*i`. The strobes captured on an address edge decide which lanes of the write data at the next edge are stored. Lanes whose strobe is 1 keep their old contents.
- R4: On an edge with `ld_adv`=1 after a selected load, the low two address bits step by one, wrapping from 3 to 0. The upper address bits stay the same, and the operation stays as loaded whatever the value of `rd_wr`.
- R5: The block is selected only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1 on a load edge. A deselecting load starts no access, and the advance edges that follow it read and write nothing.
- R6: While `clk_stall`=1, edges change no state and store no data. The read output of the current access stays valid, and a pending write completes on the first edge without a stall.
- R7: `oe_n`=1 forces `dout_en` to 0 and `dout` to zero at once, without a clock edge. Returning it to 0 within the cycle restores the read output.
- R8: While `doze`=1, `dout_en` is 0 and every other input is ignored. After `doze` returns to 0, the access held before doze resumes with the array contents unchanged.
- R9: A write to an address, followed on the next edge by a read of the same address, returns the newly merged data. A read followed at once by a write causes no output conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the access registers |
| addr | input | AW (6) | Word address, captured on load edges |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| rd_wr | input | 1 | 1 = read, 0 = write; used only on load edges |
| byte_wr_n | input | LANES (4) | Per-lane write strobes, active low |
| ld_adv | input | 1 | 0 = load new address, 1 = advance burst |
| clk_stall | input | 1 | 1 = ignore this edge and hold all state |
| oe_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Asynchronous low-power hold, active high |
| din | input | DW (32) | Write data, one cycle after its address |
| dout | output | DW (32) | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |

## Verification
The delicate cycle is the edge at which a write's data commits to the array and, on the same edge, a new read address is loaded. The bench provokes it by loading a partial-lane write to one word and then loading a read of that same word on the very next edge. It judges the result by comparing the flow-through read data in the following cycle against the merge of the old word and the written lanes, computed in the bench. The bench also lets a stall land on the commit edge, and it checks that the data stored once the stall is released is the value present on that release edge.

// File: rtl/fzt_pkg.sv
package fzt_pkg;

  // Sense of the load/advance control pin.
  typedef enum logic {
    CTL_LOAD = 1'b0,
    CTL_ADV  = 1'b1
  } ctl_e;

  // Linear step of the 2-bit burst counter, wrapping inside the aligned block.
  function automatic logic [1:0] burst_step(input logic [1:0] cur);
    return cur + 2'd1;
  endfunction

endpackage

// File: rtl/fzt_ctrl.sv
module fzt_ctrl
  import fzt_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [AW-1:0]    addr,
  input  logic             cs_ok,
  input  logic             rd_sel,
  input  logic             adv,
  input  logic [LANES-1:0] be_n,
  output logic             acc_act,
  output logic             acc_rd,
  output logic [AW-1:0]    acc_addr,
  output logic [LANES-1:0] acc_be_n
);

  logic             act_d;
  logic             rd_d;
  logic [AW-1:0]    addr_d;
  logic [LANES-1:0] be_d;

  // Next state: load opens an access, advance steps the low address bits.
  always_comb begin
    act_d  = acc_act;
    rd_d   = acc_rd;
    addr_d = acc_addr;
    be_d   = acc_be_n;
    if (step_en) begin
      be_d = be_n;
      if (ctl_e'(adv) == CTL_LOAD) begin
        act_d  = cs_ok;
        rd_d   = rd_sel;
        addr_d = addr;
      end else if (acc_act) begin
        addr_d = {acc_addr[AW-1:2], burst_step(acc_addr[1:0])};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_act  <= 1'b0;
      acc_rd   <= 1'b1;
      acc_addr <= '0;
      acc_be_n <= '1;
    end else begin
      acc_act  <= act_d;
      acc_rd   <= rd_d;
      acc_addr <= addr_d;
      acc_be_n <= be_d;
    end
  end

endmodule

// File: rtl/fzt_array.sv
module fzt_array #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [LANES-1:0]    wr_be_n,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*LW-1:0] rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !wr_be_n[g]) begin
        cells[wr_addr] <= wr_data[g*LW +: LW];
      end
    end

    assign rd_data[g*LW +: LW] = cells[rd_addr];
  end

endmodule

// File: rtl/fzt_outgate.sv
module fzt_outgate #(
  parameter int DW = 32
) (
  input  logic          oe_n,
  input  logic          doze,
  input  logic          acc_act,
  input  logic          acc_rd,
  input  logic [DW-1:0] rd_data,
  output logic          dout_en,
  output logic [DW-1:0] dout
);

  always_comb begin
    dout_en = !oe_n && !doze && acc_act && acc_rd;
    dout    = dout_en ? rd_data : '0;
  end

endmodule

// File: rtl/fzt_sram.sv
module fzt_sram #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int LW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             cs1_n,
  input  logic             cs2_n,
  input  logic             cs3,
  input  logic             rd_wr,
  input  logic [LANES-1:0] byte_wr_n,
  input  logic             ld_adv,
  input  logic             clk_stall,
  input  logic             oe_n,
  input  logic             doze,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);

  logic             step_en;
  logic             cs_ok;
  logic             wr_en;
  logic             acc_act;
  logic             acc_rd;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] acc_be_n;
  logic [DW-1:0]    rd_data;

  assign step_en = !clk_stall && !doze;
  assign cs_ok   = !cs1_n && !cs2_n && cs3;
  assign wr_en   = step_en && acc_act && !acc_rd;

  fzt_ctrl #(.AW(AW), .LANES(LANES)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .addr     (addr),
    .cs_ok    (cs_ok),
    .rd_sel   (rd_wr),
    .adv      (ld_adv),
    .be_n     (byte_wr_n),
    .acc_act  (acc_act),
    .acc_rd   (acc_rd),
    .acc_addr (acc_addr),
    .acc_be_n (acc_be_n)
  );

  fzt_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LW(LW)) array_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (acc_addr),
    .wr_be_n (acc_be_n),
    .wr_data (din),
    .rd_addr (acc_addr),
    .rd_data (rd_data)
  );

  fzt_outgate #(.DW(DW)) outgate_i (
    .oe_n    (oe_n),
    .doze    (doze),
    .acc_act (acc_act),
    .acc_rd  (acc_rd),
    .rd_data (rd_data),
    .dout_en (dout_en),
    .dout    (dout)
  );

endmodule

// File: rtl/fzt_sram_chk.sv
module fzt_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          cs1_n,
  input logic          cs2_n,
  input logic          cs3,
  input logic          ld_adv,
  input logic          clk_stall,
  input logic          doze,
  input logic          oe_n,
  input logic          dout_en,
  input logic          acc_act,
  input logic [AW-1:0] acc_addr
);

  // R2: a load edge captures the external address.
  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stall && !doze && !ld_adv) |=> (acc_addr == $past(addr)));

  // R4: an advance edge steps the low bits with wrap and keeps the upper bits.
  a_r4_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stall && !doze && ld_adv && acc_act) |=>
      ((acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])) &&
       (acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1))));

  // R5: a load with any select inactive opens no access.
  a_r5_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_stall && !doze && !ld_adv && (cs1_n || cs2_n || !cs3)) |=> !acc_act);

  // R6: a stalled edge changes no access state.
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stall |=> ($stable(acc_addr) && $stable(acc_act)));

  // R7: a high output enable never lets the drivers on.
  a_r7_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R8: doze freezes the access state and keeps the drivers off.
  a_r8_doze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> ($stable(acc_addr) && $stable(acc_act)));

  a_r8_doze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> !dout_en);

endmodule

bind fzt_sram fzt_sram_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .cs1_n     (cs1_n),
  .cs2_n     (cs2_n),
  .cs3       (cs3),
  .ld_adv    (ld_adv),
  .clk_stall (clk_stall),
  .doze      (doze),
  .oe_n      (oe_n),
  .dout_en   (dout_en),
  .acc_act   (acc_act),
  .acc_addr  (acc_addr)
);

// File: tb/fzt_sram_tb_top.sv
`timescale 1ns/1ps
module fzt_sram_tb_top;

  localparam int DEPTH = 64;
  localparam int LANES = 4;
  localparam int LW    = 8;
  localparam int AW    = 6;
  localparam int DW    = 32;

  localparam logic [DW-1:0] W0 = 32'hA0A1A2A3;
  localparam logic [DW-1:0] W1 = 32'hB0B1B2B3;
  localparam logic [DW-1:0] W2 = 32'hC0C1C2C3;
  localparam logic [DW-1:0] W3 = 32'hD0D1D2D3;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic cs1_n, cs2_n, cs3, rd_wr, ld_adv, clk_stall, oe_n, doze;
  logic [LANES-1:0] byte_wr_n;
  logic [DW-1:0] din, dout;
  logic dout_en;

  // staged stimulus, applied just after a rising edge
  logic [AW-1:0] s_addr;
  logic s_cs1_n, s_cs2_n, s_cs3, s_rd_wr, s_ld_adv, s_stall, s_oe_n, s_doze;
  logic [LANES-1:0] s_be_n;
  logic [DW-1:0] s_din;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic          en;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  fzt_sram #(.DEPTH(DEPTH), .LANES(LANES), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .cs3(cs3), .rd_wr(rd_wr), .byte_wr_n(byte_wr_n), .ld_adv(ld_adv),
    .clk_stall(clk_stall), .oe_n(oe_n), .doze(doze), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic apply();
    addr = s_addr; cs1_n = s_cs1_n; cs2_n = s_cs2_n; cs3 = s_cs3;
    rd_wr = s_rd_wr; byte_wr_n = s_be_n; ld_adv = s_ld_adv;
    clk_stall = s_stall; oe_n = s_oe_n; doze = s_doze; din = s_din;
  endtask

  task automatic set_ld(input logic [AW-1:0] a, input logic rw, input logic [LANES-1:0] be);
    s_cs1_n = 1'b0; s_cs2_n = 1'b0; s_cs3 = 1'b1;
    s_addr = a; s_rd_wr = rw; s_be_n = be; s_ld_adv = 1'b0;
  endtask

  task automatic set_idle();
    set_ld('0, 1'b1, '0);
    s_cs1_n = 1'b1;
  endtask

  task automatic set_adv();
    s_ld_adv = 1'b1;
  endtask

  // Driver: applies staged inputs and pushes the output expected in this cycle.
  task automatic tick(input logic e_en, input logic [DW-1:0] e_dat, input string tag);
    exp_t it;
    @(posedge clk);
    #1;
    apply();
    it.en   = e_en;
    it.data = e_en ? e_dat : '0;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic check_now(input string tag, input logic a_en, input logic [DW-1:0] a_dat,
                           input logic e_en, input logic [DW-1:0] e_dat);
    checks++;
    if (a_en !== e_en || a_dat !== e_dat) begin
      errors++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               tag, a_en, a_dat, e_en, e_dat);
    end
  endtask

  // Monitor: pops one expectation per cycle, away from the rising edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check_now(it.tag, dout_en, dout, it.en, it.data);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    set_idle();
    s_din = '0; s_stall = 1'b0; s_oe_n = 1'b0; s_doze = 1'b0;
    apply();
    rst_n = 1'b0;
    #2;
    check_now("R1 in reset", dout_en, dout, 1'b0, '0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    tick(1'b0, '0, "R1 after reset");                     // idle
    set_ld(6'd10, 1'b0, 4'b0000);
    tick(1'b0, '0, "R2 write load");
    set_adv(); s_rd_wr = 1'b1; s_din = W0;                // R4 rw ignored on advance
    tick(1'b0, '0, "R4 burst write beat0");
    s_din = W1; tick(1'b0, '0, "R4 burst write beat1");
    s_din = W2; tick(1'b0, '0, "R4 burst write beat2 wrap");
    s_din = W3; tick(1'b0, '0, "R4 burst write beat3");
    set_ld(6'd8, 1'b1, 4'b0000); s_din = W0;              // rewrites word 10 with W0
    tick(1'b0, '0, "R2 read load");
    set_adv(); s_din = '0;
    tick(1'b1, W2, "R4 read word 8");
    tick(1'b1, W3, "R4 read word 9");
    tick(1'b1, W0, "R4 read word 10");
    set_ld(6'd11, 1'b0, 4'b1010);
    tick(1'b1, W1, "R9 read then write");
    set_ld(6'd11, 1'b1, 4'b0000); s_din = 32'h55667788;
    tick(1'b0, '0, "R9 write then read");
    set_idle(); s_din = '0;
    tick(1'b1, 32'hB066B288, "R3 lane merge R9");
    set_adv();
    tick(1'b0, '0, "R5 deselect load");
    set_ld(6'd8, 1'b1, 4'b0000); s_cs3 = 1'b0;
    tick(1'b0, '0, "R5 advance after deselect");
    set_ld(6'd8, 1'b1, 4'b0000); s_cs2_n = 1'b1;
    tick(1'b0, '0, "R5 cs3 low");
    set_ld(6'd8, 1'b1, 4'b0000); s_cs1_n = 1'b1;
    tick(1'b0, '0, "R5 cs2_n high");
    set_ld(6'd8, 1'b1, 4'b0000);
    tick(1'b0, '0, "R5 cs1_n high");
    set_ld(6'd9, 1'b1, 4'b0000); s_stall = 1'b1;
    tick(1'b1, W2, "R5 selected read");
    set_idle(); s_stall = 1'b0;
    tick(1'b1, W2, "R6 read held over stall");
    set_ld(6'd12, 1'b0, 4'b0000);
    tick(1'b0, '0, "R6 idle");
    set_ld(6'd13, 1'b1, 4'b0000); s_stall = 1'b1; s_din = 32'hFFFF0000;
    tick(1'b0, '0, "R6 write pending");
    set_ld(6'd12, 1'b1, 4'b0000); s_stall = 1'b0; s_din = 32'h12121212;
    tick(1'b0, '0, "R6 stalled write");
    set_idle(); s_din = '0;
    tick(1'b1, 32'h12121212, "R6 write after stall");
    set_ld(6'd8, 1'b1, 4'b0000);
    tick(1'b0, '0, "R7 idle");
    set_idle(); s_oe_n = 1'b1;
    tick(1'b0, '0, "R7 oe_n high");
    #2.5 oe_n = 1'b0;
    #0.5 check_now("R7 oe_n low mid-cycle", dout_en, dout, 1'b1, W2);
    s_oe_n = 1'b0;
    set_ld(6'd9, 1'b1, 4'b0000);
    tick(1'b0, '0, "R7 deselected");
    set_ld(6'd9, 1'b0, 4'b0000); s_doze = 1'b1;
    tick(1'b0, '0, "R8 doze quiet");
    set_ld(6'd8, 1'b1, 4'b0000); s_din = 32'hFFFFFFFF;
    tick(1'b0, '0, "R8 doze inputs ignored");
    set_idle(); s_doze = 1'b0; s_din = '0;
    tick(1'b1, W3, "R8 resume after doze");
    tick(1'b0, '0, "R8 idle");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule